// File: doc/BRIEF.md
# Sign-Sign Timing Skew Estimator

This block estimates the sampling-time offset of each channel in a time-interleaved converter array. Each input sample carries a calibration error, taken as the reference channel's result minus the interleaved channel's result, together with the outputs of two reference channels. The first reference channel has full bandwidth. The second has roughly half that bandwidth. Their difference gives a coarse estimate of the input slope. The block takes the sign of the error and the sign of the slope estimate. The slope sign has a programmable dead zone around zero. The block multiplies the two signs and adds the product, scaled by a step size, into an accumulator kept for the addressed channel.

Each accumulator is a saturating fixed-point value with 5 integer bits and 10 fractional bits. Its top 5 bits form that channel's delay control word, which drives an analog delay trim. All of the control words are presented at once, so each channel's trim logic can read its own word.

Top module: `skew_sign_est`

## Requirements
- R1: After reset, every channel's 5-bit delay code is 16 (mid-scale). The accumulator holds 16384 out of a range of 0 to 32767.
- R2: The slope estimate is ref_full_i minus ref_half_i. When its magnitude is less than or equal to dz_thr_i, its sign counts as zero and the accumulator is not changed. A magnitude of dz_thr_i + 1 causes an update.
- R3: An error input of exactly zero has sign zero and causes no update.
- R4: When the error sign and the slope sign agree, the addressed accumulator rises by step_i. When they disagree, it falls by step_i.
- R5: An accepted sample changes only the accumulator selected by chan_i. At most one channel's code changes in any cycle.
- R6: The accumulator saturates at 32767 (code 31) going up and at 0 (code 0) going down. It never wraps.
- R7: Each channel's code is bits 14 down to 10 of its accumulator. Fractional steps therefore add up: with step_i = 512, two agreeing updates from mid-scale raise the code from 16 to 17, and one update leaves it at 16.
- R8: A sample accepted at clock edge n shows up in dly_code_o after clock edge n+1. The code is unchanged between edges n and n+1.
- R9: When valid_i is low, no accumulator changes, whatever the other inputs hold.
- R10: A chan_i value of 24 or more is ignored and no accumulator changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| valid_i | input | 1 | Sample strobe |
| chan_i | input | 5 | Index of the interleaved channel the sample belongs to |
| err_i | input | 12 | Signed calibration error |
| ref_full_i | input | 12 | Signed output of the full-bandwidth reference channel |
| ref_half_i | input | 12 | Signed output of the half-bandwidth reference channel |
| dz_thr_i | input | 12 | Unsigned dead-zone threshold applied to the slope magnitude |
| step_i | input | 11 | Step size in accumulator LSBs |
| dly_code_o | output | 120 | 24 delay codes of 5 bits each; channel k occupies bits 5k+4 down to 5k |

## Verification
The sign product is driven with all four combinations of error sign and slope sign. These show the rising and falling directions on separate channels. Slope values at exactly plus and minus the threshold, and one step outside it, show where the dead zone begins and ends, and a zero error separates the error-sign path from the slope-sign path. A half-code step repeated twice shows fractional accumulation. A run of large steps in each direction reaches both saturation rails. Out-of-range indices and strobe-low cycles are given update-capable data, so any leak into the accumulators would show on the outputs.

// File: rtl/skew_est_pkg.sv
package skew_est_pkg;
  typedef enum logic [1:0] {
    DIR_HOLD = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DN   = 2'd2
  } dir_e;
endpackage

// File: rtl/skew_sign_slicer.sv
module skew_sign_slicer
  import skew_est_pkg::*;
#(
  parameter int EW = 12,
  parameter int DW = 12
) (
  input  logic signed [EW-1:0] err_i,
  input  logic signed [DW-1:0] ref_full_i,
  input  logic signed [DW-1:0] ref_half_i,
  input  logic        [DW-1:0] dz_thr_i,
  output dir_e                 dir_o
);
  localparam int XW = DW + 2;

  logic signed [XW-1:0] slope;
  logic signed [XW-1:0] thr_pos;
  logic signed [XW-1:0] thr_neg;
  logic slope_pos, slope_neg, err_pos, err_neg;

  always_comb begin
    slope   = $signed({{2{ref_full_i[DW-1]}}, ref_full_i})
            - $signed({{2{ref_half_i[DW-1]}}, ref_half_i});
    thr_pos = $signed({2'b00, dz_thr_i});
    thr_neg = -thr_pos;
    slope_pos = slope > thr_pos;
    slope_neg = slope < thr_neg;
    err_pos   = (err_i != '0) && !err_i[EW-1];
    err_neg   = err_i[EW-1];
    if (!(slope_pos || slope_neg) || !(err_pos || err_neg)) dir_o = DIR_HOLD;
    else if (slope_pos == err_pos)                          dir_o = DIR_UP;
    else                                                    dir_o = DIR_DN;
  end
endmodule

// File: rtl/skew_acc_bank.sv
module skew_acc_bank
  import skew_est_pkg::*;
#(
  parameter int NCH    = 24,
  parameter int INT_W  = 5,
  parameter int FRAC_W = 10,
  parameter int MU_W   = 11,
  localparam int CH_W  = $clog2(NCH),
  localparam int ACC_W = INT_W + FRAC_W
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  upd_v_i,
  input  logic [CH_W-1:0]       upd_ch_i,
  input  dir_e                  upd_dir_i,
  input  logic [MU_W-1:0]       step_i,
  output logic [NCH*INT_W-1:0]  code_o
);
  localparam logic [ACC_W-1:0] ACC_MID = ACC_W'(1) << (ACC_W - 1);
  localparam logic [ACC_W-1:0] ACC_MAX = '1;

  logic [ACC_W-1:0] step_ext;
  assign step_ext = ACC_W'(step_i);

  for (genvar k = 0; k < NCH; k++) begin : g_ch
    logic [ACC_W-1:0] acc_q;
    logic [ACC_W:0]   sum;
    logic             hit;

    assign sum = {1'b0, acc_q} + {1'b0, step_ext};
    assign hit = upd_v_i && (upd_ch_i == CH_W'(k));

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        acc_q <= ACC_MID;
      end else if (hit) begin
        if (upd_dir_i == DIR_UP)
          acc_q <= sum[ACC_W] ? ACC_MAX : sum[ACC_W-1:0];
        else if (upd_dir_i == DIR_DN)
          acc_q <= (acc_q < step_ext) ? '0 : acc_q - step_ext;
      end
    end

    assign code_o[k*INT_W +: INT_W] = acc_q[ACC_W-1 -: INT_W];
  end
endmodule

// File: rtl/skew_sign_est.sv
module skew_sign_est
  import skew_est_pkg::*;
#(
  parameter int NCH    = 24,
  parameter int EW     = 12,
  parameter int DW     = 12,
  parameter int INT_W  = 5,
  parameter int FRAC_W = 10,
  parameter int MU_W   = 11,
  localparam int CH_W  = $clog2(NCH)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  valid_i,
  input  logic [CH_W-1:0]       chan_i,
  input  logic signed [EW-1:0]  err_i,
  input  logic signed [DW-1:0]  ref_full_i,
  input  logic signed [DW-1:0]  ref_half_i,
  input  logic [DW-1:0]         dz_thr_i,
  input  logic [MU_W-1:0]       step_i,
  output logic [NCH*INT_W-1:0]  dly_code_o
);
  dir_e            dir_d, upd_dir;
  logic            upd_v;
  logic [CH_W-1:0] upd_ch;
  logic [MU_W-1:0] upd_step;
  logic            ch_ok;

  skew_sign_slicer #(.EW(EW), .DW(DW)) u_slicer (
    .err_i      (err_i),
    .ref_full_i (ref_full_i),
    .ref_half_i (ref_half_i),
    .dz_thr_i   (dz_thr_i),
    .dir_o      (dir_d)
  );

  assign ch_ok = 32'(chan_i) < NCH;

  // sign stage register
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      upd_v    <= 1'b0;
      upd_ch   <= '0;
      upd_dir  <= DIR_HOLD;
      upd_step <= '0;
    end else begin
      upd_v    <= valid_i && ch_ok;
      upd_ch   <= chan_i;
      upd_dir  <= valid_i ? dir_d : DIR_HOLD;
      upd_step <= step_i;
    end
  end

  skew_acc_bank #(
    .NCH(NCH), .INT_W(INT_W), .FRAC_W(FRAC_W), .MU_W(MU_W)
  ) u_bank (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .upd_v_i   (upd_v),
    .upd_ch_i  (upd_ch),
    .upd_dir_i (upd_dir),
    .step_i    (upd_step),
    .code_o    (dly_code_o)
  );
endmodule

// File: rtl/skew_sign_est_chk.sv
module skew_sign_est_chk #(
  parameter int NCH   = 24,
  parameter int EW    = 12,
  parameter int DW    = 12,
  parameter int INT_W = 5
) (
  input logic                  clk_i,
  input logic                  rst_ni,
  input logic                  valid_i,
  input logic signed [EW-1:0]  err_i,
  input logic signed [DW-1:0]  ref_full_i,
  input logic signed [DW-1:0]  ref_half_i,
  input logic [DW-1:0]         dz_thr_i,
  input logic [NCH*INT_W-1:0]  dly_code_o,
  input logic                  upd_v,
  input logic [1:0]            upd_dir
);
  logic [NCH*INT_W-1:0] prev_code;
  logic [NCH-1:0]       chg;
  logic signed [DW+1:0] slope_c, thr_c;
  logic                 in_dz;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) prev_code <= {NCH{INT_W'(1) << (INT_W - 1)}};
    else         prev_code <= dly_code_o;
  end

  for (genvar k = 0; k < NCH; k++) begin : g_chg
    assign chg[k] = prev_code[k*INT_W +: INT_W] != dly_code_o[k*INT_W +: INT_W];
  end

  assign slope_c = DW'(ref_full_i) - DW'(ref_half_i);
  assign thr_c   = $signed({2'b00, dz_thr_i});
  assign in_dz   = (slope_c <= thr_c) && (slope_c >= -thr_c);

  p_dead_zone_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && in_dz) |=> (upd_dir == 2'd0));

  p_zero_err_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (valid_i && err_i == '0) |=> (upd_dir == 2'd0));

  p_one_chan_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(chg) <= 1);

  p_idle_hold_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !upd_v |=> $stable(dly_code_o));
endmodule

bind skew_sign_est skew_sign_est_chk #(
  .NCH(NCH), .EW(EW), .DW(DW), .INT_W(INT_W)
) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .valid_i    (valid_i),
  .err_i      (err_i),
  .ref_full_i (ref_full_i),
  .ref_half_i (ref_half_i),
  .dz_thr_i   (dz_thr_i),
  .dly_code_o (dly_code_o),
  .upd_v      (upd_v),
  .upd_dir    (upd_dir)
);

// File: tb/skew_sign_est_bench.sv
module skew_sign_est_bench;
  localparam int NCH = 24;
  localparam int CW  = 5;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic valid = 1'b0;
  logic [4:0] chan = '0;
  logic signed [11:0] err = '0, rfull = '0, rhalf = '0;
  logic [11:0] thr = '0;
  logic [10:0] step = '0;
  logic [NCH*CW-1:0] code;

  typedef struct {
    int                due;
    logic [NCH*CW-1:0] exp;
    string             tag;
  } item_t;

  item_t q[$];
  int model[NCH];
  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  skew_sign_est u_skew_sign_est (
    .clk_i(clk), .rst_ni(rst_n), .valid_i(valid), .chan_i(chan),
    .err_i(err), .ref_full_i(rfull), .ref_half_i(rhalf),
    .dz_thr_i(thr), .step_i(step), .dly_code_o(code)
  );

  function automatic logic [NCH*CW-1:0] pack_model();
    logic [NCH*CW-1:0] v;
    for (int k = 0; k < NCH; k++) v[k*CW +: CW] = CW'(model[k] >> 10);
    return v;
  endfunction

  task automatic check(string tag, logic [NCH*CW-1:0] act, logic [NCH*CW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic drive(int ch, int e, int f, int h, int t, int mu, bit v,
                       string tag, bit lat = 1'b0);
    int d, sd, se;
    item_t it;
    @(negedge clk);
    valid = v; chan = 5'(ch); err = 12'(e); rfull = 12'(f); rhalf = 12'(h);
    thr = 12'(t); step = 11'(mu);
    if (lat) begin
      it.due = cyc + 1; it.exp = pack_model(); it.tag = {tag, " R8 pre"};
      q.push_back(it);
    end
    d  = f - h;
    sd = (d > t) ? 1 : (d < -t) ? -1 : 0;
    se = (e > 0) ? 1 : (e < 0) ? -1 : 0;
    if (v && ch < NCH && sd * se != 0) begin
      model[ch] = model[ch] + sd * se * mu;
      if (model[ch] > 32767) model[ch] = 32767;
      if (model[ch] < 0)     model[ch] = 0;
    end
    it.due = cyc + 2; it.exp = pack_model(); it.tag = tag;
    q.push_back(it);
  endtask

  task automatic idle(int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      valid = 1'b0;
    end
  endtask

  // monitor
  initial begin
    forever begin
      @(negedge clk);
      while (q.size() > 0 && q[0].due <= cyc) begin
        item_t it;
        it = q.pop_front();
        if (it.due < cyc) begin
          n_chk++; n_bad++;
          $display("FAIL %s act=late exp=due%0d", it.tag, it.due);
        end else check(it.tag, code, it.exp);
      end
    end
  end

  // watchdog
  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < NCH; k++) model[k] = 16384;
    repeat (3) @(negedge clk);
    check("R1 reset", code, pack_model());
    rst_n = 1'b1;
    idle(2);
    check("R1 after release", code, pack_model());

    // R4 sign product directions, R8 latency
    drive(3, 5, 100, 0, 10, 1024, 1, "R4 pos/pos", 1);
    drive(3, -5, -100, 0, 10, 1024, 1, "R4 neg/neg");
    drive(5, 5, -100, 0, 10, 1024, 1, "R4 pos/neg", 1);
    drive(6, -7, 100, 0, 10, 1024, 1, "R4 neg/pos");
    idle(3);

    // R2 dead zone edges (slope = full - half)
    drive(8, 9, 80, 30, 50, 1024, 1, "R2 slope=+thr hold");
    drive(8, 9, 30, 80, 50, 1024, 1, "R2 slope=-thr hold");
    drive(8, 9, 81, 30, 50, 1024, 1, "R2 slope=thr+1 up");
    drive(8, 9, 30, 81, 50, 1024, 1, "R2 slope=-thr-1 down");
    drive(8, 9, -2000, -2000, 0, 1024, 1, "R2 slope=0 thr=0 hold");
    idle(3);

    // R3 zero error
    drive(4, 0, 500, 0, 0, 1024, 1, "R3 zero err");
    idle(3);

    // R7 fractional steps
    drive(7, 3, 200, 0, 0, 512, 1, "R7 half step");
    idle(2);
    drive(7, 3, 200, 0, 0, 512, 1, "R7 second half step");
    idle(3);

    // R9 strobe low with update data
    drive(2, 100, 500, 0, 0, 2047, 0, "R9 valid low");
    drive(2, -100, 500, 0, 0, 2047, 0, "R9 valid low down");
    idle(3);

    // R10 out-of-range index
    drive(24, 100, 500, 0, 0, 2047, 1, "R10 chan 24");
    drive(31, 100, 500, 0, 0, 2047, 1, "R10 chan 31");
    idle(3);

    // R6 saturation both ways, back-to-back
    for (int i = 0; i < 20; i++) drive(9, 50, 400, 0, 0, 2047, 1, "R6 sat high");
    for (int i = 0; i < 20; i++) drive(10, -50, 400, 0, 0, 2047, 1, "R6 sat low");
    idle(3);

    // R5 interleaved channels back-to-back
    for (int i = 0; i < NCH; i++)
      drive(i, (i % 2) ? 20 : -20, 300, 0, 0, 1024 + 37 * i, 1, "R5 sweep");
    drive(0, 20, 300, 0, 0, 1024, 1, "R5 ch0");
    drive(23, -20, 300, 0, 0, 1024, 1, "R5 ch23");
    idle(4);

    while (q.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule